// File: doc/BRIEF.md
# Digitizer Arm Trigger Controller

This block decides when a sampling digitizer takes an arm event. Software programs it through a small write-only register port: a control register, an arm limit, an arm delay and a sample configuration byte. Two further addresses act as command strobes. A write of any value to one of them is an immediate software arm. A write to the other is an initiate command. An initiate command starts an acquisition and clears the count of accepted arms.

Once initiated, the block waits for an arm. The arm comes from one of eight external pulse lines, chosen in the control register, or from the software strobe. Each accepted arm increments a saturating counter and starts a delay countdown. At the end of the countdown the block gives a one-cycle armed strobe. It then goes back to waiting, or drops to idle if the limit has been reached. A hold bit blocks the external lines and leaves only the software strobe. An infinite bit suspends the limit while the counter keeps running, so clearing the infinite bit can send the block straight to idle. The delay can run on every clock, on a divide-by-ten tick, or on a cascaded divide-by-hundred tick.

Top module: `arm_trig_ctrl`

## Requirements
- R1: After a synchronous reset the state is idle (0), the accepted-arm count is 0, armed is low, the pre/post flag is low and the sample configuration output is 0x20.
- R2: A write to address 5 moves the block to waiting (state 1) and clears the count, both visible after that write's clock edge.
- R3: While waiting, a pulse on the external line selected by control bits 7:5 is accepted: the count rises by one and the state becomes delaying (2) at that edge. A pulse on any other line is ignored.
- R4: With control bit 2 (hold) set, external pulses are ignored. A write to address 4 still arms.
- R5: A software arm and an external arm in the same cycle are counted as one accepted arm.
- R6: With control bit 0 set, the armed strobe rises exactly D+1 cycles after the accepting edge, where D is the delay register (address 2). It lasts one cycle, and no arm is accepted while the delay runs.
- R7: With bits 0 and 4 clear, a delay D≥1 ends between (D-1)·10+2 and D·10+1 cycles after the accepting edge. D=0 ends after 1 cycle.
- R8: With bit 0 clear and bit 4 set, a delay D≥1 ends between (D-1)·100+2 and D·100+1 cycles after the accepting edge.
- R9: Without infinite mode, the state after the armed strobe is idle if the count has reached the limit (address 1). Otherwise it is waiting.
- R10: With control bit 1 (infinite) set, the block keeps waiting after every arm, and the count keeps rising and saturates at 255.
- R11: If infinite mode is cleared while waiting with count ≥ limit, the block goes idle one cycle after the control write's edge. With count < limit it keeps accepting arms until the limit is reached.
- R12: In idle, neither external pulses nor software arms change the state or the count.
- R13: The pre/post flag output follows control bit 3, and the sample configuration output holds the last write to address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 control, 1 limit, 2 delay, 3 sample config, 4 software arm, 5 initiate) |
| wr_data | input | 8 | Write data |
| ext_arm | input | 8 | External single-cycle arm pulses, one per source |
| state_o | output | 2 | 0 idle, 1 waiting, 2 delaying |
| arm_cnt_o | output | 8 | Accepted-arm count |
| armed_o | output | 1 | One-cycle strobe at the end of the arm delay |
| prearm_o | output | 1 | Pre/post arm readings enabled |
| samp_cfg_o | output | 8 | Sample configuration byte |

## Verification
On every cycle the assertions check several properties. Initiate always lands in waiting with a zero count. Idle is left only through initiate. The count never falls except on initiate. Hold always blocks an external-only arm. The armed strobe is a single cycle and comes only out of the delaying state. The exact delay lengths, the source selection, the limit-versus-infinite transitions and saturation can only be shown by the bench's scenarios, because they depend on register history and on the divider phase.

// File: rtl/arm_trig_pkg.sv
package arm_trig_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DELAY = 2'd2
  } arm_state_t;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_LIMIT = 3'd1;
  localparam logic [ADDR_W-1:0] A_DELAY = 3'd2;
  localparam logic [ADDR_W-1:0] A_SAMP  = 3'd3;
  localparam logic [ADDR_W-1:0] A_IMM   = 3'd4;
  localparam logic [ADDR_W-1:0] A_INIT  = 3'd5;

  localparam logic [REG_W-1:0] SAMP_RST  = 8'h20;
  localparam logic [REG_W-1:0] LIMIT_RST = 8'h01;

  // control byte, msb first
  typedef struct packed {
    logic [2:0] src;     // 7:5 external source select
    logic       reclk;   // 4   cascade divider stage
    logic       prearm;  // 3   pre/post arm readings
    logic       hold;    // 2   block external arms
    logic       inf;     // 1   infinite arms
    logic       fast;    // 0   delay on every clock
  } ctrl_t;
endpackage

// File: rtl/arm_tick_div.sv
module arm_tick_div #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] wrap_inc(input logic [CW-1:0] v);
    return (v == LAST) ? '0 : v + CW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= wrap_inc(cnt);
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/arm_ctrl_regs.sv
module arm_ctrl_regs import arm_trig_pkg::*; #(
  parameter int RW = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [RW-1:0] wr_data,
  output ctrl_t         ctrl,
  output logic [RW-1:0] limit,
  output logic [RW-1:0] delay,
  output logic [RW-1:0] samp,
  output logic          imm_stb,
  output logic          init_stb
);
  function automatic logic hit(input logic en, input logic [AW-1:0] a,
                               input logic [AW-1:0] want);
    return en && (a == want);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      limit <= LIMIT_RST;
      delay <= '0;
      samp  <= SAMP_RST;
    end else begin
      if (hit(wr_en, wr_addr, A_CTRL))  ctrl  <= ctrl_t'(wr_data);
      if (hit(wr_en, wr_addr, A_LIMIT)) limit <= wr_data;
      if (hit(wr_en, wr_addr, A_DELAY)) delay <= wr_data;
      if (hit(wr_en, wr_addr, A_SAMP))  samp  <= wr_data;
    end
  end

  assign imm_stb  = hit(wr_en, wr_addr, A_IMM);
  assign init_stb = hit(wr_en, wr_addr, A_INIT);
endmodule

// File: rtl/arm_seq.sv
module arm_seq import arm_trig_pkg::*; #(
  parameter int CNT_W = REG_W,
  parameter int DLY_W = REG_W,
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] limit,
  input  logic [DLY_W-1:0] delay,
  input  logic             imm_stb,
  input  logic             init_stb,
  input  logic [N_SRC-1:0] ext_arm,
  input  logic             tb_tick,
  output arm_state_t       state,
  output logic [CNT_W-1:0] count,
  output logic             armed,
  output logic             accept
);
  logic [DLY_W-1:0] dly;
  logic             ext_hit;
  logic             done;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + CNT_W'(1);
  endfunction

  function automatic logic limit_met(input logic [CNT_W-1:0] c,
                                     input logic [CNT_W-1:0] l,
                                     input logic inf);
    return !inf && (c >= l);
  endfunction

  assign ext_hit = ext_arm[ctrl.src] && !ctrl.hold;
  assign done    = limit_met(count, limit, ctrl.inf);
  assign accept  = (state == ST_WAIT) && !init_stb && !done &&
                   (imm_stb || ext_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      count <= '0;
      dly   <= '0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b0;
      if (init_stb) begin
        state <= ST_WAIT;
        count <= '0;
      end else begin
        case (state)
          ST_WAIT: begin
            if (done) begin
              state <= ST_IDLE;
            end else if (accept) begin
              state <= ST_DELAY;
              count <= sat_inc(count);
              dly   <= delay;
            end
          end
          ST_DELAY: begin
            if (dly == '0) begin
              armed <= 1'b1;
              state <= done ? ST_IDLE : ST_WAIT;
            end else if (tb_tick) begin
              dly <= dly - DLY_W'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/arm_trig_ctrl.sv
module arm_trig_ctrl import arm_trig_pkg::*; #(
  parameter int N_SRC  = 8,
  parameter int DIV    = 10,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [N_SRC-1:0]  ext_arm,
  output logic [1:0]        state_o,
  output logic [REG_W-1:0]  arm_cnt_o,
  output logic              armed_o,
  output logic              prearm_o,
  output logic [REG_W-1:0]  samp_cfg_o
);
  ctrl_t            ctrl_w;
  logic [REG_W-1:0] limit_w, delay_w;
  logic             imm_stb_w, init_stb_w, accept_w, hold_w, tb_tick_w;
  logic [STAGES:0]  tick_chain;
  arm_state_t       state_w;

  arm_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl_w), .limit(limit_w), .delay(delay_w), .samp(samp_cfg_o),
    .imm_stb(imm_stb_w), .init_stb(init_stb_w)
  );

  // cascaded divide-by-DIV stages: stage i advances on stage i-1's tick
  assign tick_chain[0] = 1'b1;
  for (genvar i = 0; i < STAGES; i++) begin : g_div
    arm_tick_div #(.DIV(DIV)) u_div (
      .clk(clk), .rst(rst), .en(tick_chain[i]), .tick(tick_chain[i+1])
    );
  end

  assign tb_tick_w = ctrl_w.fast ? 1'b1 :
                     (ctrl_w.reclk ? tick_chain[STAGES] : tick_chain[1]);
  assign hold_w    = ctrl_w.hold;

  arm_seq #(.N_SRC(N_SRC)) u_seq (
    .clk(clk), .rst(rst), .ctrl(ctrl_w), .limit(limit_w), .delay(delay_w),
    .imm_stb(imm_stb_w), .init_stb(init_stb_w), .ext_arm(ext_arm),
    .tb_tick(tb_tick_w), .state(state_w), .count(arm_cnt_o),
    .armed(armed_o), .accept(accept_w)
  );

  assign state_o  = state_w;
  assign prearm_o = ctrl_w.prearm;
endmodule

// File: rtl/arm_trig_chk.sv
module arm_trig_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] state,
  input logic [7:0] count,
  input logic       armed,
  input logic       accept,
  input logic       imm_stb,
  input logic       init_stb,
  input logic       hold
);
  // R2
  init_to_wait_chk: assert property (@(posedge clk) disable iff (rst)
    init_stb |=> (state == 2'd1) && (count == 8'd0));

  // R12
  idle_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd0) && !init_stb |=> (state == 2'd0));

  // R4
  hold_block_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd1) && hold && !imm_stb |-> !accept);

  // R10
  count_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !init_stb |=> (count >= $past(count)));

  // R6
  armed_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> ($past(state) == 2'd2));

  // R6
  armed_single_chk: assert property (@(posedge clk) disable iff (rst)
    armed |=> !armed);
endmodule

bind arm_trig_ctrl arm_trig_chk chk_i (
  .clk(clk), .rst(rst), .state(state_o), .count(arm_cnt_o),
  .armed(armed_o), .accept(accept_w), .imm_stb(imm_stb_w),
  .init_stb(init_stb_w), .hold(hold_w)
);

// File: tb/arm_trig_ctrl_tb.sv
`timescale 1ns/1ps
module arm_trig_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] ext_arm = '0;
  logic [1:0] state_o;
  logic [7:0] arm_cnt_o;
  logic       armed_o, prearm_o;
  logic [7:0] samp_cfg_o;

  int  nvec = 0;
  int  nfail = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  arm_trig_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_arm(ext_arm), .state_o(state_o), .arm_cnt_o(arm_cnt_o),
    .armed_o(armed_o), .prearm_o(prearm_o), .samp_cfg_o(samp_cfg_o)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    nvec++;
    if (act < lo || act > hi) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic do_init();
    wr(5, 0);
    chk("R2 state", state_o, 1);
    chk("R2 count", arm_cnt_o, 0);
  endtask

  task automatic arm_ext(input int s);
    ext_arm = 8'(1 << s);
    step();
    ext_arm = '0;
  endtask

  task automatic wait_armed(output int lat);
    lat = 0;
    do begin
      step();
      lat++;
    end while (!armed_o && lat < 1000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int lat;
    int exp_cnt;
    repeat (3) step();
    rst = 1'b0;
    // R1
    chk("R1 state", state_o, 0);
    chk("R1 count", arm_cnt_o, 0);
    chk("R1 armed", armed_o, 0);
    chk("R1 prearm", prearm_o, 0);
    chk("R1 samp", samp_cfg_o, 32);

    // R13
    wr(0, 8'h08);
    chk("R13 prearm set", prearm_o, 1);
    wr(3, 8'hA5);
    chk("R13 samp", samp_cfg_o, 8'hA5);
    wr(0, 8'h00);
    chk("R13 prearm clr", prearm_o, 0);

    // R12: idle ignores everything
    ext_arm = '1; step(); ext_arm = '0;
    wr(4, 0);
    chk("R12 state", state_o, 0);
    chk("R12 count", arm_cnt_o, 0);

    // R3 / R6 / R9 sweep over source select, pulse line and delay
    wr(1, 255);
    for (int s = 0; s < 8; s++) begin
      wr(0, (s << 5) | 1);
      wr(2, s);
      for (int p = 0; p < 8; p++) begin
        do_init();
        arm_ext(p);
        chk("R3 count", arm_cnt_o, (p == s) ? 1 : 0);
        chk("R3 state", state_o, (p == s) ? 2 : 1);
        if (p == s) begin
          lat = 0;
          ext_arm = '1;
          do begin
            step();
            lat++;
          end while (!armed_o && lat < 50);
          ext_arm = '0;
          chk("R6 latency", lat, s + 1);
          chk("R6 no accept in delay", arm_cnt_o, 1);
          chk("R9 below limit", state_o, 1);
          step();
          chk("R6 one cycle", armed_o, 0);
        end
      end
    end

    // R4 hold
    wr(0, 8'h05);
    wr(2, 0);
    do_init();
    arm_ext(0);
    chk("R4 ext blocked count", arm_cnt_o, 0);
    chk("R4 ext blocked state", state_o, 1);
    wr(4, 0);
    chk("R4 imm count", arm_cnt_o, 1);
    chk("R4 imm state", state_o, 2);

    // R5 coincident software and external arm
    wr(0, 8'h01);
    do_init();
    ext_arm = 8'h01; wr_en = 1'b1; wr_addr = 3'd4; step();
    ext_arm = '0; wr_en = 1'b0;
    chk("R5 counted once", arm_cnt_o, 1);
    step();
    chk("R5 still once", arm_cnt_o, 1);

    // R9 finite limit of 2
    wr(1, 2);
    do_init();
    arm_ext(0); wait_armed(lat);
    chk("R9 first count", arm_cnt_o, 1);
    chk("R9 first state", state_o, 1);
    arm_ext(0); wait_armed(lat);
    chk("R9 second count", arm_cnt_o, 2);
    chk("R9 limit idle", state_o, 0);

    // R10 infinite with saturation
    wr(0, 8'h03);
    do_init();
    for (int i = 0; i < 300; i++) begin
      arm_ext(0);
      wait_armed(lat);
      exp_cnt = (i + 1 > 255) ? 255 : i + 1;
      if (i % 50 == 0 || i > 252) chk("R10 count", arm_cnt_o, exp_cnt);
    end
    chk("R10 waiting", state_o, 1);
    // R11 clear infinite above limit
    wr(0, 8'h01);
    chk("R11 same edge", state_o, 1);
    step();
    chk("R11 idle", state_o, 0);

    // R11 clear infinite below limit
    wr(1, 10);
    wr(0, 8'h03);
    do_init();
    for (int i = 0; i < 3; i++) begin arm_ext(0); wait_armed(lat); end
    wr(0, 8'h01);
    step();
    chk("R11 keeps waiting", state_o, 1);
    for (int i = 3; i < 10; i++) begin
      arm_ext(0); wait_armed(lat);
      chk("R11 progress", state_o, (i == 9) ? 0 : 1);
    end
    chk("R11 final count", arm_cnt_o, 10);

    // R7 divide by ten timebase
    wr(1, 255);
    wr(0, 8'h00);
    for (int d = 0; d < 5; d++) begin
      wr(2, d);
      do_init();
      arm_ext(0);
      wait_armed(lat);
      if (d == 0) chk("R7 zero delay", lat, 1);
      else chk_rng("R7 latency", lat, (d - 1) * 10 + 2, d * 10 + 1);
    end

    // R8 cascaded divide by hundred
    wr(0, 8'h10);
    for (int d = 1; d < 4; d++) begin
      wr(2, d);
      do_init();
      arm_ext(0);
      wait_armed(lat);
      chk_rng("R8 latency", lat, (d - 1) * 100 + 2, d * 100 + 1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule